// File: doc/BRIEF.md
# Dual-Buffer Serial DMA Channel

This block moves bytes between a serial controller's byte FIFO and system memory. It works through two buffers, A and B, that take turns. Software gives each buffer a first address and a last address, then arms it. The channel works through the armed buffer one byte at a time. For each byte it issues a memory request with a ready/valid handshake. A buffer is disarmed once its next address would pass its last address. The channel then moves on to the other buffer if that one is armed, so software can refill one buffer while the other is in use.

The parameter `IS_RX` sets the direction. In receive mode, each FIFO byte becomes a memory write, and each buffer keeps its own byte count. In transmit mode, each memory read becomes a FIFO push, and one byte count is shared by both buffers. The last address of a buffer can be rewritten while the buffer is in use. In receive mode a buffer's count can also be rewritten. Either rewrite can end the buffer early, and a receive count write to an idle buffer also arms it.

Top module: `dbdma_chan`

## Requirements
- R1: After a synchronous reset, both buffers are disarmed, `active_valid` is 0, both counts read 0, no memory request is raised, and buffer A is the first candidate.
- R2: Receive mode. A FIFO byte is taken (`rx_ready`) only in a cycle where a buffer is in use and `mem_ready` is high. `mem_req` is high when a buffer is in use and `rx_valid` is high. The write goes to `mem_addr` = first address + that buffer's count, with `mem_we`=1 and `mem_wdata`=`rx_data`. Each completed byte adds one to that buffer's count.
- R3: An armed buffer is disarmed when its first address plus its count is greater than its last address. On the clock edge that disarms it, the buffer's `unload_*` output goes high for exactly one cycle, in the same cycle that its `loaded_*` output falls. After that edge the buffer moves no further bytes.
- R4: The buffer in use is the armed buffer that was armed earliest. If both buffers are armed in the same cycle from idle, A is used first (`active_b`=0). When the buffer in use is disarmed, the channel switches to the other buffer if that buffer is armed.
- R5: Arming a buffer with `load_a`/`load_b` resets its receive count to 0.
- R6: A write to a buffer's last address (`cfg_field`=1) takes effect on the next edge. If the new value is below first address + count, the buffer is disarmed on the edge after that. If it is not below, the buffer stays armed.
- R7: Receive mode, count write (`cfg_field`=2). If the buffer is armed, the count takes the written value and the buffer stays armed. If the buffer is idle, the count takes the written value and the buffer becomes armed.
- R8: Transmit mode. `mem_req` (a read, `mem_we`=0) is raised only when a buffer is in use and `tx_space` is high. The read address is first address + shared count. When `mem_ready` completes the read, `tx_push` pulses and `tx_data`=`mem_rdata`.
- R9: Transmit mode. The shared count goes up by one for each completed read. It is reset to 0 when either buffer is armed or when the buffer in use changes. Otherwise it keeps its value. Both `count_a` and `count_b` show it.
- R10: Transmit mode. Count writes (`cfg_field`=2) and writes with `cfg_field`=3 change no count and arm no buffer. `cfg_field` codes: 0 first address, 1 last address, 2 count, 3 unused. `cfg_buf`: 0 selects A, 1 selects B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_field | input | 2 | 0 first address, 1 last address, 2 count, 3 unused |
| cfg_buf | input | 1 | 0 = buffer A, 1 = buffer B |
| cfg_data | input | AW | Write data |
| load_a | input | 1 | Arm buffer A |
| load_b | input | 1 | Arm buffer B |
| rx_valid | input | 1 | Receive FIFO has a byte |
| rx_data | input | 8 | Receive FIFO byte |
| rx_ready | output | 1 | Receive byte taken this cycle |
| tx_space | input | 1 | Transmit FIFO can accept a byte |
| tx_push | output | 1 | Push `tx_data` into the transmit FIFO |
| tx_data | output | 8 | Byte for the transmit FIFO |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_ready` |
| mem_ready | input | 1 | Memory accepts or completes the request |
| loaded_a | output | 1 | Buffer A armed |
| loaded_b | output | 1 | Buffer B armed |
| active_valid | output | 1 | A buffer is in use |
| active_b | output | 1 | Buffer in use is B |
| unload_a | output | 1 | One-cycle pulse when A is disarmed |
| unload_b | output | 1 | One-cycle pulse when B is disarmed |
| count_a | output | AW | Count of A (shared count in transmit mode) |
| count_b | output | AW | Count of B (shared count in transmit mode) |

## Verification
The first pattern streams steadily with a memory that stalls every third cycle. This separates correct stalls from bytes that are lost or repeated, and it shows whether the switch from one buffer to the other is correct.

Further patterns try the following:
- Arming B through a receive count write before arming A, which shows whether the buffer in use is chosen by arming order rather than by letter.
- Arming both buffers together from idle, which shows A priority.
- Rewriting a last address below the current fill, and a count into a buffer that is in use, which shows immediate early ending apart from ending at the normal last byte.

A final stretch of pseudo-random FIFO, memory and arming activity runs in lockstep against a behavioural model. It mixes collisions that the directed cases never line up, such as an arm landing on the same edge as a disarm.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;
  typedef enum logic [1:0] {
    FLD_FIRST = 2'd0,
    FLD_LAST  = 2'd1,
    FLD_COUNT = 2'd2,
    FLD_SPARE = 2'd3
  } cfg_field_e;

  localparam int BYTE_W = 8;
  localparam int NBUF   = 2;
endpackage

// File: rtl/dbdma_buf.sv
module dbdma_buf #(
  parameter int AW      = 16,
  parameter bit OWN_CNT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_first,
  input  logic          wr_last,
  input  logic          wr_cnt,
  input  logic [AW-1:0] wdata,
  input  logic          load_req,
  input  logic          xfer,
  input  logic          is_cur,
  input  logic [AW-1:0] ext_cnt,
  output logic          armed,
  output logic          armed_d,
  output logic [AW-1:0] cnt,
  output logic [AW-1:0] first,
  output logic [AW-1:0] last,
  output logic          spent,
  output logic          unload_pulse
);
  logic          armed_q, pulse_q, rearm;
  logic [AW-1:0] first_q, last_q;
  logic [AW:0]   next_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      last_q  <= '0;
    end else begin
      if (wr_first) first_q <= wdata;
      if (wr_last)  last_q  <= wdata;
    end
  end

  generate
    if (OWN_CNT) begin : g_own
      logic [AW-1:0] cnt_q;
      logic          unused_own;
      assign unused_own = ^ext_cnt;
      always_ff @(posedge clk) begin
        if (rst)           cnt_q <= '0;
        else if (load_req) cnt_q <= '0;
        else if (wr_cnt)   cnt_q <= wdata;
        else if (xfer)     cnt_q <= cnt_q + AW'(1);
      end
      assign cnt = cnt_q;

      p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (xfer && !load_req && !wr_cnt) |=> (cnt_q == $past(cnt_q) + AW'(1)));
      p_load_clears_r5: assert property (@(posedge clk) disable iff (rst)
        load_req |=> (cnt_q == '0));
    end else begin : g_shared
      logic unused_sh;
      assign unused_sh = wr_cnt ^ xfer;
      assign cnt = ext_cnt;
    end
  endgenerate

  assign next_sum = {1'b0, first_q} + {1'b0, cnt};
  assign spent    = armed_q && (next_sum > {1'b0, last_q}) && (OWN_CNT || is_cur);
  assign rearm    = load_req || (OWN_CNT && wr_cnt && !armed_q);
  assign armed_d  = rearm || (armed_q && !spent);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pulse_q <= spent && !rearm;
    end
  end

  assign armed        = armed_q;
  assign unload_pulse = pulse_q;
  assign first        = first_q;
  assign last         = last_q;

  p_pulse_unarmed_r3: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> !armed_q);
  p_spent_drops_r3: assert property (@(posedge clk) disable iff (rst)
    (spent && !rearm) |=> (!armed_q && pulse_q));
endmodule

// File: rtl/dbdma_sel.sv
module dbdma_sel (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] armed_q,
  input  logic [1:0] armed_d,
  output logic       cur,
  output logic       switched
);
  logic cur_q, cur_n;

  always_comb begin
    cur_n = cur_q;
    if (armed_q == 2'b00) begin
      if (armed_d[0])      cur_n = 1'b0;
      else if (armed_d[1]) cur_n = 1'b1;
    end else if (!armed_d[cur_q] && armed_d[~cur_q]) begin
      cur_n = ~cur_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cur_q <= 1'b0;
    else     cur_q <= cur_n;
  end

  assign cur      = cur_q;
  assign switched = (cur_n != cur_q);

  p_cur_is_armed_r4: assert property (@(posedge clk) disable iff (rst)
    (armed_q != 2'b00) |-> armed_q[cur_q]);
  p_a_first_r4: assert property (@(posedge clk) disable iff (rst)
    (armed_q == 2'b00 && armed_d == 2'b11) |=> (cur_q == 1'b0));
endmodule

// File: rtl/dbdma_chan.sv
module dbdma_chan #(
  parameter int AW    = 16,
  parameter bit IS_RX = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_field,
  input  logic          cfg_buf,
  input  logic [AW-1:0] cfg_data,
  input  logic          load_a,
  input  logic          load_b,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          rx_ready,
  input  logic          tx_space,
  output logic          tx_push,
  output logic [7:0]    tx_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ready,
  output logic          loaded_a,
  output logic          loaded_b,
  output logic          active_valid,
  output logic          active_b,
  output logic          unload_a,
  output logic          unload_b,
  output logic [AW-1:0] count_a,
  output logic [AW-1:0] count_b
);
  import dbdma_pkg::*;

  logic [NBUF-1:0] armed_q, armed_d, spent, pulse, load_v;
  logic [AW-1:0]   cnt_v   [NBUF];
  logic [AW-1:0]   first_v [NBUF];
  logic [AW-1:0]   last_v  [NBUF];
  logic [AW-1:0]   shared_cnt;
  logic            cur, switched, go, xfer;

  assign load_v = {load_b, load_a};

  dbdma_sel u_sel (
    .clk(clk), .rst(rst), .armed_q(armed_q), .armed_d(armed_d),
    .cur(cur), .switched(switched)
  );

  generate
    for (genvar i = 0; i < NBUF; i++) begin : g_buf
      logic sel_me;
      assign sel_me = cfg_wr && (cfg_buf == 1'(i));
      dbdma_buf #(.AW(AW), .OWN_CNT(IS_RX)) u_buf (
        .clk(clk), .rst(rst),
        .wr_first(sel_me && cfg_field == FLD_FIRST),
        .wr_last (sel_me && cfg_field == FLD_LAST),
        .wr_cnt  (sel_me && cfg_field == FLD_COUNT),
        .wdata(cfg_data), .load_req(load_v[i]),
        .xfer(xfer && (cur == 1'(i))), .is_cur(cur == 1'(i)),
        .ext_cnt(shared_cnt),
        .armed(armed_q[i]), .armed_d(armed_d[i]), .cnt(cnt_v[i]),
        .first(first_v[i]), .last(last_v[i]), .spent(spent[i]),
        .unload_pulse(pulse[i])
      );
    end
  endgenerate

  assign active_valid = |armed_q;
  assign go           = active_valid && !spent[cur];
  assign mem_addr     = first_v[cur] + cnt_v[cur];

  generate
    if (IS_RX) begin : g_rx
      logic unused_rx;
      assign unused_rx  = ^{mem_rdata, tx_space, switched};
      assign shared_cnt = '0;
      assign mem_req    = go && rx_valid;
      assign rx_ready   = go && mem_ready;
      assign xfer       = go && rx_valid && mem_ready;
      assign mem_we     = 1'b1;
      assign mem_wdata  = rx_data;
      assign tx_push    = 1'b0;
      assign tx_data    = '0;
    end else begin : g_tx
      logic [AW-1:0] sh_q;
      logic          unused_tx;
      assign unused_tx = ^{rx_data, rx_valid};
      always_ff @(posedge clk) begin
        if (rst)                          sh_q <= '0;
        else if (load_a || load_b || switched) sh_q <= '0;
        else if (xfer)                    sh_q <= sh_q + AW'(1);
      end
      assign shared_cnt = sh_q;
      assign mem_req    = go && tx_space;
      assign xfer       = go && tx_space && mem_ready;
      assign rx_ready   = 1'b0;
      assign mem_we     = 1'b0;
      assign mem_wdata  = '0;
      assign tx_push    = xfer;
      assign tx_data    = mem_rdata;

      p_tx_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (load_a || load_b) |=> (sh_q == '0));
    end
  endgenerate

  assign loaded_a = armed_q[0];
  assign loaded_b = armed_q[1];
  assign active_b = cur;
  assign unload_a = pulse[0];
  assign unload_b = pulse[1];
  assign count_a  = cnt_v[0];
  assign count_b  = cnt_v[1];

  p_req_needs_active_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> active_valid);
  p_addr_in_window_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr <= last_v[cur] && mem_addr >= first_v[cur]));
  p_tx_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (!IS_RX && mem_req) |-> tx_space);
endmodule

// File: tb/dbdma_chan_bench.sv
module dbdma_chan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int MASK = 32'h0000_FFFF;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wr = 0, cfg_buf = 0, load_a = 0, load_b = 0;
  logic [1:0] cfg_field = 0;
  logic [AW-1:0] cfg_data = 0;
  logic rx_valid = 0, tx_space = 0, mem_ready = 0;
  logic [7:0] rx_data = 0;

  logic r_rx_ready, r_tx_push, r_req, r_we, r_la, r_lb, r_av, r_ab, r_ua, r_ub;
  logic [7:0] r_tx_data, r_wdata;
  logic [AW-1:0] r_addr, r_ca, r_cb;
  logic t_rx_ready, t_tx_push, t_req, t_we, t_la, t_lb, t_av, t_ab, t_ua, t_ub;
  logic [7:0] t_tx_data, t_wdata, t_rdata;
  logic [AW-1:0] t_addr, t_ca, t_cb;

  assign t_rdata = t_addr[7:0] ^ 8'h5A;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbdma_chan #(.AW(AW), .IS_RX(1'b1)) u_dbdma_chan (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_field(cfg_field), .cfg_buf(cfg_buf),
    .cfg_data(cfg_data), .load_a(load_a), .load_b(load_b), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(r_rx_ready), .tx_space(tx_space), .tx_push(r_tx_push),
    .tx_data(r_tx_data), .mem_req(r_req), .mem_we(r_we), .mem_addr(r_addr),
    .mem_wdata(r_wdata), .mem_rdata(8'h00), .mem_ready(mem_ready), .loaded_a(r_la),
    .loaded_b(r_lb), .active_valid(r_av), .active_b(r_ab), .unload_a(r_ua),
    .unload_b(r_ub), .count_a(r_ca), .count_b(r_cb));

  dbdma_chan #(.AW(AW), .IS_RX(1'b0)) u_dbdma_chan_tx (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_field(cfg_field), .cfg_buf(cfg_buf),
    .cfg_data(cfg_data), .load_a(load_a), .load_b(load_b), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(t_rx_ready), .tx_space(tx_space), .tx_push(t_tx_push),
    .tx_data(t_tx_data), .mem_req(t_req), .mem_we(t_we), .mem_addr(t_addr),
    .mem_wdata(t_wdata), .mem_rdata(t_rdata), .mem_ready(mem_ready), .loaded_a(t_la),
    .loaded_b(t_lb), .active_valid(t_av), .active_b(t_ab), .unload_a(t_ua),
    .unload_b(t_ub), .count_a(t_ca), .count_b(t_cb));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural model, index d: 0 receive channel, 1 transmit channel
  int m_first [2][2];
  int m_last  [2][2];
  int m_cnt   [2][2];
  bit m_arm   [2][2];
  bit m_pulse [2][2];
  int m_cur   [2];

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int mc(int d, int i);
    return (d == 0) ? m_cnt[d][i] : m_cnt[d][0];
  endfunction
  function automatic bit m_spent(int d, int i);
    return m_arm[d][i] && (m_first[d][i] + mc(d, i) > m_last[d][i]) && (d == 0 || i == m_cur[d]);
  endfunction
  function automatic bit m_go(int d);
    return (m_arm[d][0] || m_arm[d][1]) && !m_spent(d, m_cur[d]);
  endfunction
  function automatic bit m_req(int d);
    return m_go(d) && ((d == 0) ? rx_valid : tx_space);
  endfunction
  function automatic int m_addr(int d);
    return (m_first[d][m_cur[d]] + mc(d, m_cur[d])) & MASK;
  endfunction

  task automatic m_step(int d);
    bit sp[2], wc[2], ld[2], re[2], na[2];
    bit xf;
    int nc, n;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_first[d][i] = 0; m_last[d][i] = 0; m_cnt[d][i] = 0;
        m_arm[d][i] = 0; m_pulse[d][i] = 0;
      end
      m_cur[d] = 0;
      return;
    end
    xf = m_req(d) && mem_ready;
    for (int i = 0; i < 2; i++) begin
      sp[i] = m_spent(d, i);
      wc[i] = cfg_wr && cfg_field == 2 && cfg_buf == i[0];
      ld[i] = (i == 0) ? load_a : load_b;
      re[i] = ld[i] || (d == 0 && wc[i] && !m_arm[d][i]);
      na[i] = re[i] || (m_arm[d][i] && !sp[i]);
    end
    nc = m_cur[d];
    if (!m_arm[d][0] && !m_arm[d][1]) begin
      if (na[0]) nc = 0; else if (na[1]) nc = 1;
    end else if (!na[m_cur[d]] && na[1 - m_cur[d]]) nc = 1 - m_cur[d];
    if (d == 0) begin
      for (int i = 0; i < 2; i++) begin
        n = m_cnt[d][i];
        if (xf && m_cur[d] == i) n = (n + 1) & MASK;
        if (wc[i]) n = int'(cfg_data);
        if (ld[i]) n = 0;
        m_cnt[d][i] = n;
      end
    end else begin
      n = m_cnt[d][0];
      if (xf) n = (n + 1) & MASK;
      if (load_a || load_b || nc != m_cur[d]) n = 0;
      m_cnt[d][0] = n; m_cnt[d][1] = n;
    end
    for (int i = 0; i < 2; i++) begin
      if (cfg_wr && cfg_buf == i[0] && cfg_field == 0) m_first[d][i] = int'(cfg_data);
      if (cfg_wr && cfg_buf == i[0] && cfg_field == 1) m_last[d][i] = int'(cfg_data);
      m_pulse[d][i] = sp[i] && !re[i];
      m_arm[d][i] = na[i];
    end
    m_cur[d] = nc;
  endtask

  task automatic cmp_comb();
    chk("R2", "rx mem_req", int'(r_req), int'(m_req(0)));
    chk("R2", "rx_ready", int'(r_rx_ready), int'(m_go(0) && mem_ready));
    if (m_req(0)) begin
      chk("R2", "rx mem_addr", int'(r_addr), m_addr(0));
      chk("R2", "rx mem_wdata", int'(r_wdata), int'(rx_data));
      chk("R2", "rx mem_we", int'(r_we), 1);
    end
    chk("R8", "tx mem_req", int'(t_req), int'(m_req(1)));
    chk("R8", "tx_push", int'(t_tx_push), int'(m_req(1) && mem_ready));
    if (m_req(1)) begin
      chk("R8", "tx mem_addr", int'(t_addr), m_addr(1));
      chk("R8", "tx mem_we", int'(t_we), 0);
      chk("R8", "tx_data", int'(t_tx_data), (m_addr(1) & 8'hFF) ^ 8'h5A);
    end
  endtask

  task automatic cmp_state();
    chk("R3", "rx loaded_a", int'(r_la), int'(m_arm[0][0]));
    chk("R3", "rx loaded_b", int'(r_lb), int'(m_arm[0][1]));
    chk("R3", "rx unload_a", int'(r_ua), int'(m_pulse[0][0]));
    chk("R3", "rx unload_b", int'(r_ub), int'(m_pulse[0][1]));
    chk("R4", "rx active_valid", int'(r_av), int'(m_arm[0][0] || m_arm[0][1]));
    if (r_av) chk("R4", "rx active_b", int'(r_ab), m_cur[0]);
    chk("R2", "rx count_a", int'(r_ca), m_cnt[0][0]);
    chk("R2", "rx count_b", int'(r_cb), m_cnt[0][1]);
    chk("R3", "tx loaded_a", int'(t_la), int'(m_arm[1][0]));
    chk("R3", "tx loaded_b", int'(t_lb), int'(m_arm[1][1]));
    chk("R3", "tx unload_a", int'(t_ua), int'(m_pulse[1][0]));
    chk("R3", "tx unload_b", int'(t_ub), int'(m_pulse[1][1]));
    chk("R4", "tx active_valid", int'(t_av), int'(m_arm[1][0] || m_arm[1][1]));
    if (t_av) chk("R4", "tx active_b", int'(t_ab), m_cur[1]);
    chk("R9", "tx count_a", int'(t_ca), m_cnt[1][0]);
    chk("R9", "tx count_b", int'(t_cb), m_cnt[1][0]);
  endtask

  task automatic tick();
    #1;
    if (!rst) cmp_comb();
    @(posedge clk);
    m_step(0);
    m_step(1);
    @(negedge clk);
    if (!rst) cmp_state();
  endtask

  task automatic cfg(input logic [1:0] f, input logic b, input int v);
    cfg_wr = 1; cfg_field = f; cfg_buf = b; cfg_data = AW'(v);
    tick();
    cfg_wr = 0;
  endtask

  task automatic arm(input logic a, input logic b);
    load_a = a; load_b = b;
    tick();
    load_a = 0; load_b = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    tick(); tick(); tick();
    rst = 0;
    #1;
    // R1 reset state
    chk("R1", "rx loaded", int'({r_la, r_lb}), 0);
    chk("R1", "tx active_valid", int'(t_av), 0);
    chk("R1", "rx counts", int'(r_ca | r_cb), 0);
    chk("R1", "mem_req", int'(r_req | t_req), 0);
    chk("R1", "first candidate", int'(t_ab), 0);
    cfg(0, 0, 16'h0010); cfg(1, 0, 16'h0013);
    cfg(0, 1, 16'h0020); cfg(1, 1, 16'h0021);
    cfg(2, 1, 1);
    chk("R7", "rx idle count write arms B", int'(r_lb), 1);
    chk("R7", "rx count_b kept", int'(r_cb), 1);
    chk("R10", "tx count write no arm", int'(t_lb), 0);
    chk("R10", "tx count unchanged", int'(t_cb), 0);
    cfg(3, 0, 16'h0077);
    chk("R10", "tx spare field no effect", int'(t_ca), 0);
    arm(1, 0);
    chk("R4", "rx earlier-armed B in use", int'(r_ab), 1);
    chk("R4", "tx A in use", int'(t_ab), 0);
    rx_valid = 1; tx_space = 1;
    for (int k = 0; k < 20; k++) begin
      mem_ready = (k % 3) != 0; rx_data = 8'(8'hC0 + k);
      tick();
    end
    rx_valid = 0; tx_space = 0; mem_ready = 0;
    chk("R3", "rx both unloaded", int'({r_la, r_lb}), 0);
    chk("R2", "rx count_a after fill", int'(r_ca), 4);
    chk("R2", "rx count_b after fill", int'(r_cb), 2);
    chk("R9", "tx count kept after unload", int'(t_ca), 4);
    arm(1, 0);
    chk("R5", "rx load clears count", int'(r_ca), 0);
    chk("R9", "tx load clears count", int'(t_ca), 0);
    cfg(2, 0, 2);
    chk("R7", "rx count write while armed", int'(r_ca), 2);
    chk("R7", "rx stays armed", int'(r_la), 1);
    chk("R10", "tx count write ignored", int'(t_ca), 0);
    cfg(1, 0, 16'h0011);
    tick();
    chk("R6", "rx early unload on end rewrite", int'(r_la), 0);
    chk("R6", "tx stays armed within new end", int'(t_la), 1);
    cfg(1, 0, 16'h000F);
    tick();
    chk("R6", "tx early unload on end rewrite", int'(t_la), 0);
    cfg(1, 0, 16'h0013);
    arm(1, 1);
    chk("R4", "rx A priority", int'(r_ab), 0);
    chk("R4", "tx A priority", int'(t_ab), 0);
    rx_valid = 1; tx_space = 1; mem_ready = 1;
    for (int k = 0; k < 14; k++) begin
      rx_data = 8'(k * 7);
      tick();
    end
    for (int k = 0; k < 400; k++) begin
      int r;
      r = int'($urandom);
      rx_valid = r[0]; tx_space = r[1]; mem_ready = r[2] | r[3];
      rx_data = r[15:8];
      if (r[20:18] == 3'd0) begin
        load_a = r[21]; load_b = r[22] | ~r[21];
      end else if (r[20:18] == 3'd1) begin
        cfg_wr = 1; cfg_field = {1'b0, r[23]}; cfg_buf = r[24];
        cfg_data = AW'((r[24] ? 32'h20 : 32'h10) + (r[23] ? 32'(r[27:25]) : 0));
      end else if (r[20:18] == 3'd2) begin
        cfg_wr = 1; cfg_field = 2'd2; cfg_buf = r[24]; cfg_data = AW'(r[26:25]);
      end
      tick();
      load_a = 0; load_b = 0; cfg_wr = 0;
    end
    done = 1;
    summary();
    $finish;
  end
endmodule